// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupts

This block is a single general-purpose I/O bank of two to eight pins, controlled through a small 32-bit register bus. Each pin has a 4-bit function nibble. The nibble selects one of three roles: plain input, driven output, or interrupt source. A data register sets the levels that output pins drive. Reading the data register returns the synchronized level of every pin.

A pin in interrupt mode watches its synchronized level according to a 3-bit trigger code, which can select a low or high level, a falling or rising edge, or both edges. Events latch into a pending register, and software clears that register by writing ones. The single interrupt line is the OR of all pending bits whose mask bit is cleared. Pending bits keep latching while their pin is masked, so software can poll events that it chose not to be interrupted by.

Top module: `gpio_eint_bank`

## Requirements
- R1: After reset the function, trigger, pending and data-output registers are all zero, every mask bit is one, `irq_o` is low and no output enable is asserted.
- R2: Pin n's function is bits [4n+3:4n] of the function register at byte offset 0x00. Code 0x1 asserts `pin_oe_o[n]`, and `pin_o[n]` always carries bit n of the data register at offset 0x04. Code 0x0 and every code other than 0x1 leave the enable low.
- R3: A read of offset 0x04 returns the pin levels after a two-flop synchronizer. A change on `pin_i` is visible after the second rising clock edge, and not after the first.
- R4: With function 0xF and trigger code 3, a rising edge on the pin sets its pending bit (offset 0x10) at the third rising clock edge after the input change. A falling edge does not set it.
- R5: Trigger code 2 sets pending on a falling edge only. Code 4 sets pending on both edges. Pin n's trigger code sits in bits [4n+2:4n] of offset 0x08.
- R6: Trigger codes 0 (low level) and 1 (high level) set pending on every cycle that the level holds. A clear written while the level persists leaves the bit set.
- R7: Trigger codes 5 to 7 never set pending. A function code other than 0xF never sets pending, whatever the trigger code.
- R8: `irq_o` is high exactly when some pending bit has its mask bit (offset 0x0C) at zero. Pending still latches while the pin is masked.
- R9: Writing a 1 to a bit of offset 0x10 clears that pending bit, and writing a 0 leaves it unchanged. Writing back a value just read clears every bit that was set.
- R10: Function nibbles, trigger fields and per-pin bits at or above NUM_PINS read as zero and ignore writes. The trigger nibbles read with bit 3 at zero.
- R11: Reads return zero when `sel_i` is low or when the address is outside offsets 0x00, 0x04, 0x08, 0x0C and 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | Write when high, read when low |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address |
| pin_i | input | NUM_PINS | Raw pin levels, asynchronous |
| pin_o | output | NUM_PINS | Driven output levels |
| pin_oe_o | output | NUM_PINS | Output enables |
| irq_o | output | 1 | Bank interrupt |

## Verification
A corrupted function or trigger field shows up as soon as that register is read back. It shows up a second time three clock edges after the next pin transition, when a pending bit appears where none should, or fails to appear. A stuck synchronizer stage delays or hides the data-register value one or two edges after the input changes. A clear that does not win or lose against a persisting level reveals itself in the very next read of the pending register. A pending or mask bit in the wrong state drives `irq_o` wrongly in the same cycle.

// File: rtl/gpio_eint_pkg.sv
package gpio_eint_pkg;
  localparam int ADDR_W = 5;

  localparam logic [3:0] FN_IN   = 4'h0;
  localparam logic [3:0] FN_OUT  = 4'h1;
  localparam logic [3:0] FN_EINT = 4'hF;

  localparam logic [2:0] TRG_LOW  = 3'd0;
  localparam logic [2:0] TRG_HIGH = 3'd1;
  localparam logic [2:0] TRG_FALL = 3'd2;
  localparam logic [2:0] TRG_RISE = 3'd3;
  localparam logic [2:0] TRG_BOTH = 3'd4;

  localparam logic [ADDR_W-1:0] OFS_FUNC = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DATA = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_PEND = 5'h10;

  function automatic logic event_hit(logic [2:0] code, logic cur, logic prv);
    logic hit;
    case (code)
      TRG_LOW:  hit = !cur;
      TRG_HIGH: hit = cur;
      TRG_FALL: hit = prv && !cur;
      TRG_RISE: hit = !prv && cur;
      TRG_BOTH: hit = prv ^ cur;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/gpio_eint_sync.sv
module gpio_eint_sync #(
  parameter int NUM_PINS = 6,
  parameter int STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] prev_o
);
  logic [STAGES-1:0][NUM_PINS-1:0] stg_q;
  logic [NUM_PINS-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_eint_regs.sv
module gpio_eint_regs
  import gpio_eint_pkg::*;
#(
  parameter int NUM_PINS = 6,
  localparam int FW = 4 * NUM_PINS,
  localparam int TW = 3 * NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] pend_i,
  output logic [FW-1:0]       func_o,
  output logic [NUM_PINS-1:0] data_o,
  output logic [TW-1:0]       trig_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] pend_clr_o
);
  logic [FW-1:0]       func_q;
  logic [NUM_PINS-1:0] data_q;
  logic [TW-1:0]       trig_q;
  logic [NUM_PINS-1:0] mask_q;
  logic                wr_en;
  logic                unused_wdata;

  assign wr_en        = sel_i && wr_i;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_q <= '0;
      data_q <= '0;
      trig_q <= '0;
      mask_q <= '1;
    end else if (wr_en) begin
      case (addr_i)
        OFS_FUNC: func_q <= wdata_i[FW-1:0];
        OFS_DATA: data_q <= wdata_i[NUM_PINS-1:0];
        OFS_TRIG: for (int i = 0; i < NUM_PINS; i++) trig_q[3*i +: 3] <= wdata_i[4*i +: 3];
        OFS_MASK: mask_q <= wdata_i[NUM_PINS-1:0];
        default: ;
      endcase
    end
  end

  assign pend_clr_o = (wr_en && addr_i == OFS_PEND) ? wdata_i[NUM_PINS-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (addr_i)
        OFS_FUNC: rdata_o[FW-1:0] = func_q;
        OFS_DATA: rdata_o[NUM_PINS-1:0] = lvl_i;
        OFS_TRIG: for (int i = 0; i < NUM_PINS; i++) rdata_o[4*i +: 3] = trig_q[3*i +: 3];
        OFS_MASK: rdata_o[NUM_PINS-1:0] = mask_q;
        OFS_PEND: rdata_o[NUM_PINS-1:0] = pend_i;
        default: ;
      endcase
    end
  end

  assign func_o = func_q;
  assign data_o = data_q;
  assign trig_o = trig_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/gpio_eint_detect.sv
module gpio_eint_detect
  import gpio_eint_pkg::*;
#(
  parameter int NUM_PINS = 6,
  localparam int FW = 4 * NUM_PINS,
  localparam int TW = 3 * NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [FW-1:0]       func_i,
  input  logic [TW-1:0]       trig_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] prev_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] pend_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic hit;
    logic pend_q;

    assign hit = (func_i[4*i +: 4] == FN_EINT) &&
                 event_hit(trig_i[3*i +: 3], lvl_i[i], prev_i[i]);

    // a new event outranks a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= (pend_q && !clr_i[i]) || hit;
    end

    assign pend_o[i] = pend_q;
  end
endmodule

// File: rtl/gpio_eint_bank.sv
module gpio_eint_bank
  import gpio_eint_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [4:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam int FW = 4 * NUM_PINS;
  localparam int TW = 3 * NUM_PINS;

  logic [FW-1:0]       func_q;
  logic [TW-1:0]       trig_q;
  logic [NUM_PINS-1:0] data_q;
  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] pend_q;
  logic [NUM_PINS-1:0] pend_clr;
  logic [NUM_PINS-1:0] lvl_q;
  logic [NUM_PINS-1:0] prev_q;

  gpio_eint_sync #(.NUM_PINS(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .lvl_o  (lvl_q),
    .prev_o (prev_q)
  );

  gpio_eint_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .lvl_i      (lvl_q),
    .pend_i     (pend_q),
    .func_o     (func_q),
    .data_o     (data_q),
    .trig_o     (trig_q),
    .mask_o     (mask_q),
    .pend_clr_o (pend_clr)
  );

  gpio_eint_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .func_i (func_q),
    .trig_i (trig_q),
    .lvl_i  (lvl_q),
    .prev_i (prev_q),
    .clr_i  (pend_clr),
    .pend_o (pend_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_oe
    assign pin_oe_o[i] = (func_q[4*i +: 4] == FN_OUT);
  end

  assign pin_o = data_q;
  assign irq_o = |(pend_q & ~mask_q);
endmodule

// File: rtl/gpio_eint_checker.sv
module gpio_eint_checker
  import gpio_eint_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sel_i,
  input logic                  wr_i,
  input logic [4:0]            addr_i,
  input logic [31:0]           wdata_i,
  input logic [31:0]           rdata_o,
  input logic [NUM_PINS-1:0]   pin_oe_o,
  input logic                  irq_o,
  input logic [4*NUM_PINS-1:0] func_q,
  input logic [3*NUM_PINS-1:0] trig_q,
  input logic [NUM_PINS-1:0]   mask_q,
  input logic [NUM_PINS-1:0]   pend_q,
  input logic [NUM_PINS-1:0]   lvl_q,
  input logic [NUM_PINS-1:0]   prev_q
);
  a_r8_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);

  a_r10_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && (addr_i == OFS_DATA || addr_i == OFS_MASK || addr_i == OFS_PEND))
      |-> (rdata_o[31:NUM_PINS] == '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    a_r4_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (func_q[4*i +: 4] == FN_EINT && trig_q[3*i +: 3] == TRG_RISE && lvl_q[i] && !prev_q[i])
        |=> pend_q[i]);

    a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (func_q[4*i +: 4] != FN_EINT && !pend_q[i]) |=> !pend_q[i]);

    a_r9_clear_wins_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && wr_i && addr_i == OFS_PEND && wdata_i[i] && func_q[4*i +: 4] != FN_EINT)
        |=> !pend_q[i]);

    a_r2_oe_output_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_oe_o[i] |-> (func_q[4*i +: 4] == FN_OUT));
  end
endmodule

bind gpio_eint_bank gpio_eint_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pin_oe_o (pin_oe_o),
  .irq_o    (irq_o),
  .func_q   (func_q),
  .trig_q   (trig_q),
  .mask_q   (mask_q),
  .pend_q   (pend_q),
  .lvl_q    (lvl_q),
  .prev_q   (prev_q)
);

// File: tb/gpio_eint_bank_bench.sv
module gpio_eint_bank_bench;
  localparam int N = 6;
  localparam logic [31:0] ALL = 32'h3F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0;
  logic          wr = 1'b0;
  logic [4:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  pins = '0;
  logic [N-1:0]  pout;
  logic [N-1:0]  poe;
  logic          irq;
  int            n_vec = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  gpio_eint_bank #(.NUM_PINS(N)) u_gpio_eint_bank (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pout),
    .pin_oe_o(poe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    chk(tag, rdata, exp);
    sel = 1'b0;
  endtask

  task automatic restore();
    wr_reg(5'h00, 32'h0);
    wr_reg(5'h08, 32'h0);
    wr_reg(5'h0C, ALL);
    wr_reg(5'h04, 32'h0);
    pins = '0;
    cyc(4);
    wr_reg(5'h10, ALL);
  endtask

  task automatic t_reset();
    rd_chk("R1 func", 5'h00, 0);
    rd_chk("R1 trig", 5'h08, 0);
    rd_chk("R1 mask", 5'h0C, ALL);
    rd_chk("R1 pend", 5'h10, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 oe", {26'b0, poe}, 0);
    chk("R1 pin_o", {26'b0, pout}, 0);
  endtask

  task automatic t_regmap();
    wr_reg(5'h00, 32'hFFFF_FFFF);
    rd_chk("R10 func upper", 5'h00, 32'h00FF_FFFF);
    wr_reg(5'h00, 32'h0);
    wr_reg(5'h08, 32'hFFFF_FFFF);
    rd_chk("R10 trig nibbles", 5'h08, 32'h0077_7777);
    wr_reg(5'h08, 32'h0);
    wr_reg(5'h0C, 32'h0);
    rd_chk("R11 mask zero", 5'h0C, 0);
    wr_reg(5'h0C, 32'hFFFF_FFFF);
    rd_chk("R10 mask upper", 5'h0C, ALL);
    wr_reg(5'h14, 32'hFFFF_FFFF);
    rd_chk("R11 unmapped", 5'h14, 0);
    sel = 1'b0; addr = 5'h0C; #1;
    chk("R11 no sel", rdata, 0);
  endtask

  task automatic t_output();
    wr_reg(5'h00, 32'h0000_0100);
    chk("R2 oe pin2", {26'b0, poe}, 32'h04);
    wr_reg(5'h04, 32'hFFFF_FFFF);
    chk("R2 pin_o", {26'b0, pout}, ALL);
    wr_reg(5'h00, 32'h0000_0200);
    chk("R2 other code no oe", {26'b0, poe}, 0);
    restore();
  endtask

  task automatic t_input();
    pins = 6'b101001;
    cyc(1);
    rd_chk("R3 after one edge", 5'h04, 0);
    cyc(1);
    rd_chk("R3 after two edges", 5'h04, 32'h29);
    restore();
  endtask

  task automatic t_rise();
    wr_reg(5'h08, 32'h3);
    wr_reg(5'h00, 32'hF);
    wr_reg(5'h0C, 32'h3E);
    wr_reg(5'h10, ALL);
    pins[0] = 1'b1;
    cyc(2);
    rd_chk("R4 not yet", 5'h10, 0);
    cyc(1);
    rd_chk("R4 rise pend", 5'h10, 1);
    chk("R8 irq unmasked", {31'b0, irq}, 1);
    wr_reg(5'h10, 32'h0);
    rd_chk("R9 zero keeps", 5'h10, 1);
    wr_reg(5'h10, 32'h1);
    rd_chk("R9 one clears", 5'h10, 0);
    chk("R8 irq low after clear", {31'b0, irq}, 0);
    pins[0] = 1'b0;
    cyc(5);
    rd_chk("R4 fall ignored", 5'h10, 0);
    restore();
  endtask

  task automatic t_fall_both();
    wr_reg(5'h08, 32'h2);
    wr_reg(5'h00, 32'hF);
    pins[0] = 1'b1; cyc(5);
    rd_chk("R5 rise ignored by fall", 5'h10, 0);
    pins[0] = 1'b0; cyc(5);
    rd_chk("R5 fall pend", 5'h10, 1);
    wr_reg(5'h10, 32'h1);
    wr_reg(5'h08, 32'h4);
    pins[0] = 1'b1; cyc(5);
    rd_chk("R5 both rise", 5'h10, 1);
    wr_reg(5'h10, 32'h1);
    pins[0] = 1'b0; cyc(5);
    rd_chk("R5 both fall", 5'h10, 1);
    restore();
  endtask

  task automatic t_level();
    wr_reg(5'h08, 32'h1);
    wr_reg(5'h00, 32'hF);
    wr_reg(5'h10, ALL);
    rd_chk("R6 high idle", 5'h10, 0);
    pins[0] = 1'b1; cyc(3);
    rd_chk("R6 high pend", 5'h10, 1);
    wr_reg(5'h10, 32'h1);
    rd_chk("R6 clear lost to level", 5'h10, 1);
    pins[0] = 1'b0; cyc(3);
    wr_reg(5'h10, 32'h1);
    cyc(2);
    rd_chk("R6 cleared after drop", 5'h10, 0);
    wr_reg(5'h08, 32'h0);
    cyc(1);
    rd_chk("R6 low pend", 5'h10, 1);
    wr_reg(5'h08, 32'h3);
    wr_reg(5'h10, 32'h1);
    rd_chk("R6 low stopped", 5'h10, 0);
    restore();
  endtask

  task automatic t_nop_codes();
    wr_reg(5'h08, 32'h5);
    wr_reg(5'h00, 32'hF);
    for (int c = 5; c < 8; c++) begin
      wr_reg(5'h08, 32'(c));
      pins[0] = 1'b1; cyc(4);
      pins[0] = 1'b0; cyc(4);
      rd_chk($sformatf("R7 trig code %0d", c), 5'h10, 0);
    end
    wr_reg(5'h08, 32'h4);
    wr_reg(5'h00, 32'h2);
    pins[0] = 1'b1; cyc(4);
    rd_chk("R7 func 2 reads as input", 5'h04, 1);
    pins[0] = 1'b0; cyc(4);
    rd_chk("R7 func 2 no pend", 5'h10, 0);
    restore();
  endtask

  task automatic t_mask();
    wr_reg(5'h08, 32'h3);
    wr_reg(5'h00, 32'hF);
    pins[0] = 1'b1; cyc(4);
    rd_chk("R8 latch while masked", 5'h10, 1);
    chk("R8 irq masked", {31'b0, irq}, 0);
    wr_reg(5'h0C, 32'h3E);
    chk("R8 irq after unmask", {31'b0, irq}, 1);
    wr_reg(5'h10, 32'h1);
    chk("R8 irq after ack", {31'b0, irq}, 0);
    restore();
  endtask

  task automatic t_multi();
    wr_reg(5'h08, 32'h0030_0003);
    wr_reg(5'h00, 32'h00F0_000F);
    wr_reg(5'h0C, 32'h1E);
    pins = 6'b100001; cyc(4);
    rd_chk("R4 two pins", 5'h10, 32'h21);
    chk("R8 irq top pin", {31'b0, irq}, 1);
    wr_reg(5'h10, 32'h21);
    rd_chk("R9 write back clears", 5'h10, 0);
    restore();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_regmap();
    restore();
    t_output();
    t_input();
    t_rise();
    t_fall_both();
    t_level();
    t_nop_codes();
    t_mask();
    t_multi();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule